// File: doc/BRIEF.md
# Dual-Port RAM Port Controller

This block is a memory with two independent access ports, called left and right. Each port has its own address, 9-bit write data, 9-bit read data, a read/write strobe, an active-low output enable, a pair of chip enables of opposite polarity and an active-low semaphore select. On every clock edge each port's controls are sampled and decoded into one of four operations: deselected, write, read, or read with outputs disabled. Both ports may read the same word in the same cycle. Read data is returned one cycle after the read is sampled. Because the model uses no tri-state nets, a separate data-valid flag per port shows whether the data outputs would be driven.

When both ports reach the same word in one cycle and at least one of them writes, a collision arbiter picks a winner. The port that was already on that word in the previous cycle wins. If both arrive together, the left port wins. The losing port's write is dropped, and its active-low busy flag goes low on the next cycle. A master/slave input sets the busy direction. A master drives busy from its own arbiter. A slave ignores its arbiter and instead takes per-port busy inputs from a master, which block that port's writes. Cascading devices this way gives wider words.

The address width is a parameter. The full-size part uses 15 bits (32K words). The default is kept small.

Top module: `dpram_port_ctrl`

## Requirements
- R1: A port is selected only when its chip enable 0 is low and its chip enable 1 is high. With any other combination the port neither writes nor reads, and its data-valid output is 0 on the next cycle.
- R2: A selected port with read/write low (0 = write) and semaphore select high writes its data at its address on that clock edge, whatever its output enable is.
- R3: A selected port with read/write high, output enable low and semaphore select high sets its data-valid flag to 1 on the next cycle. Its read data then carries the word held before that edge, so a same-cycle write by the other port is not yet visible.
- R4: When data-valid is 0, read data is all zeros. A selected port with output enable high, or with semaphore select low, gives data-valid 0 on the next cycle.
- R5: Both ports may read the same address in the same cycle. Both then get the stored word, and neither busy flag goes low.
- R6: In master mode (master/slave input = 1), suppose both ports are active on the same address in one cycle, at least one writes, and one port was active on that address in the previous cycle while the other was not. The earlier port wins. The other port's write is suppressed, and its busy output is 0 on the next cycle. Both busy outputs are never 0 at the same time.
- R7: If both ports arrive at the colliding address in the same cycle, the left port wins and the right port is the loser. While the collision continues on that address, the loser stays the same.
- R8: A busy output returns to 1 on the cycle after the first cycle in which the address collision is gone.
- R9: In slave mode (master/slave input = 0), both busy outputs are 1 one cycle later. A port's write is blocked when its busy input is 0 at that edge. The internal arbiter suppresses nothing.
- R10: While reset is low, both data-valid flags are 0, both read data buses are 0 and both busy outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples all controls |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_i | input | 1 | 1 = master (busy driven), 0 = slave (busy taken as input) |
| l_ce0_n | input | 1 | Left chip enable, active low |
| l_ce1 | input | 1 | Left chip enable, active high |
| l_rw | input | 1 | Left read/write, 1 = read, 0 = write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_sem_n | input | 1 | Left semaphore select, active low; must be high for memory access |
| l_addr | input | AW | Left address |
| l_wdata | input | DW | Left write data |
| l_busy_in_n | input | 1 | Left busy input in slave mode, active low |
| l_rdata | output | DW | Left read data |
| l_doe | output | 1 | Left data-valid (outputs would be driven) |
| l_busy_n | output | 1 | Left busy flag, active low |
| r_ce0_n | input | 1 | Right chip enable, active low |
| r_ce1 | input | 1 | Right chip enable, active high |
| r_rw | input | 1 | Right read/write, 1 = read, 0 = write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_sem_n | input | 1 | Right semaphore select, active low; must be high for memory access |
| r_addr | input | AW | Right address |
| r_wdata | input | DW | Right write data |
| r_busy_in_n | input | 1 | Right busy input in slave mode, active low |
| r_rdata | output | DW | Right read data |
| r_doe | output | 1 | Right data-valid |
| r_busy_n | output | 1 | Right busy flag, active low |

## Verification
A wrong arrival record in the arbiter shows up one cycle after a collision: the busy flag goes low on the wrong port. A later read of the contested word then returns the loser's data instead of the winner's. If the record goes stale, busy stays low for a cycle or more after the addresses part. A bad read register or decode shows on the very next cycle as a wrong data-valid flag, or as read data that differs from the value last written.

// File: rtl/dpr_pkg.sv
// Shared types for the dual-port RAM controller.
// Assumes: nothing beyond a SystemVerilog-2017 toolchain.
package dpr_pkg;

    // Decoded per-port request for one sampled cycle
    typedef struct packed {
        logic act;   // port selected with semaphore select high (memory cycle)
        logic wr;    // memory write requested
        logic rd;    // memory read with outputs enabled
    } port_req_t;

endpackage

// File: rtl/dpr_port_decode.sv
// Decodes one port's raw controls into a memory request.
// Assumes: all controls are sampled synchronously by the caller; purely combinational.
module dpr_port_decode
    import dpr_pkg::*;
(
    input  logic      ce0_n,
    input  logic      ce1,
    input  logic      rw,
    input  logic      oe_n,
    input  logic      sem_n,
    output port_req_t req
);

    logic sel;

    // Port selection needs the low enable low and the high enable high
    always_comb begin
        sel     = !ce0_n && ce1;
        req.act = sel && sem_n;
        req.wr  = req.act && !rw;
        req.rd  = req.act && rw && !oe_n;
    end

endmodule

// File: rtl/dpr_arbiter.sv
// Same-address collision arbiter with master/slave busy handling.
// The winner is the port active on the address in the previous cycle; on a tie, left.
// A running collision keeps its loser. Busy is registered; write gating is same-cycle.
// Assumes: requests come from dpr_port_decode; busy inputs are only used in slave mode.
module dpr_arbiter #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ms_i,
    input  logic          act_l,
    input  logic          act_r,
    input  logic          wr_l,
    input  logic          wr_r,
    input  logic [AW-1:0] addr_l,
    input  logic [AW-1:0] addr_r,
    input  logic          busy_in_l_n,
    input  logic          busy_in_r_n,
    output logic          wen_l,
    output logic          wen_r,
    output logic          busy_l_n,
    output logic          busy_r_n
);

    logic          hist_act_l, hist_act_r;
    logic [AW-1:0] hist_addr_l, hist_addr_r;
    logic          coll_q, loser_r_q;
    logic          coll, left_early, right_early, keep, loser_r;

    // Collision detection and winner selection for the current cycle
    always_comb begin
        coll        = act_l && act_r && (addr_l == addr_r) && (wr_l || wr_r);
        left_early  = hist_act_l && (hist_addr_l == addr_l);
        right_early = hist_act_r && (hist_addr_r == addr_r);
        keep        = coll_q && (hist_addr_l == addr_l);
        if (keep)
            loser_r = loser_r_q;
        else
            loser_r = !(right_early && !left_early);
    end

    // Write gating: own arbiter in master mode, external busy in slave mode
    always_comb begin
        if (ms_i) begin
            wen_l = wr_l && !(coll && !loser_r);
            wen_r = wr_r && !(coll && loser_r);
        end else begin
            wen_l = wr_l && busy_in_l_n;
            wen_r = wr_r && busy_in_r_n;
        end
    end

    // Arrival history, collision memory and registered busy flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_act_l  <= 1'b0;
            hist_act_r  <= 1'b0;
            hist_addr_l <= '0;
            hist_addr_r <= '0;
            coll_q      <= 1'b0;
            loser_r_q   <= 1'b0;
            busy_l_n    <= 1'b1;
            busy_r_n    <= 1'b1;
        end else begin
            hist_act_l  <= act_l;
            hist_act_r  <= act_r;
            hist_addr_l <= addr_l;
            hist_addr_r <= addr_r;
            coll_q      <= coll;
            loser_r_q   <= loser_r;
            busy_l_n    <= !(ms_i && coll && !loser_r);
            busy_r_n    <= !(ms_i && coll && loser_r);
        end
    end

endmodule

// File: rtl/dpr_mem_core.sv
// Two-port storage array with read-first registered read per port.
// Assumes: simultaneous writes to one address only occur in slave mode; left then wins.
// The array has no reset; read registers and valid flags do.
module dpr_mem_core #(
    parameter int AW = 8,
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_l,
    input  logic [AW-1:0] addr_r,
    input  logic [DW-1:0] wdata_l,
    input  logic [DW-1:0] wdata_r,
    input  logic          wen_l,
    input  logic          wen_r,
    input  logic          ren_l,
    input  logic          ren_r,
    output logic [DW-1:0] rdata_l,
    output logic [DW-1:0] rdata_r,
    output logic          doe_l,
    output logic          doe_r
);

    localparam int DEPTH = 1 << AW;
    localparam int NPORT = 2;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] addr_p  [NPORT];
    logic          ren_p   [NPORT];
    logic [DW-1:0] q_p     [NPORT];
    logic          vld_p   [NPORT];
    logic [DW-1:0] out_p   [NPORT];

    // Gather per-port read controls into arrays
    always_comb begin
        addr_p[0] = addr_l;
        addr_p[1] = addr_r;
        ren_p[0]  = ren_l;
        ren_p[1]  = ren_r;
    end

    // Array write; the left write is applied last so it wins a same-address clash
    always_ff @(posedge clk) begin
        if (wen_r) mem[addr_r] <= wdata_r;
        if (wen_l) mem[addr_l] <= wdata_l;
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        // Read-first registered read and valid flag for port p
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q_p[p]   <= '0;
                vld_p[p] <= 1'b0;
            end else begin
                vld_p[p] <= ren_p[p];
                if (ren_p[p]) q_p[p] <= mem[addr_p[p]];
            end
        end
        // Zero the bus whenever it would be high impedance
        assign out_p[p] = vld_p[p] ? q_p[p] : '0;
    end

    assign rdata_l = out_p[0];
    assign rdata_r = out_p[1];
    assign doe_l   = vld_p[0];
    assign doe_r   = vld_p[1];

endmodule

// File: rtl/dpram_port_ctrl.sv
// Top of the dual-port RAM controller: two decoders, the collision arbiter and the array.
// Assumes: one clock samples both ports; AW sets depth (2**AW words of DW bits).
module dpram_port_ctrl #(
    parameter int AW = 8,
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ms_i,
    input  logic          l_ce0_n,
    input  logic          l_ce1,
    input  logic          l_rw,
    input  logic          l_oe_n,
    input  logic          l_sem_n,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_wdata,
    input  logic          l_busy_in_n,
    output logic [DW-1:0] l_rdata,
    output logic          l_doe,
    output logic          l_busy_n,
    input  logic          r_ce0_n,
    input  logic          r_ce1,
    input  logic          r_rw,
    input  logic          r_oe_n,
    input  logic          r_sem_n,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_wdata,
    input  logic          r_busy_in_n,
    output logic [DW-1:0] r_rdata,
    output logic          r_doe,
    output logic          r_busy_n
);

    import dpr_pkg::*;

    port_req_t req_l, req_r;
    logic      wen_l, wen_r;

    dpr_port_decode u_dec_l (
        .ce0_n (l_ce0_n), .ce1 (l_ce1), .rw (l_rw), .oe_n (l_oe_n),
        .sem_n (l_sem_n), .req (req_l)
    );

    dpr_port_decode u_dec_r (
        .ce0_n (r_ce0_n), .ce1 (r_ce1), .rw (r_rw), .oe_n (r_oe_n),
        .sem_n (r_sem_n), .req (req_r)
    );

    dpr_arbiter #(.AW(AW)) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .ms_i        (ms_i),
        .act_l       (req_l.act),
        .act_r       (req_r.act),
        .wr_l        (req_l.wr),
        .wr_r        (req_r.wr),
        .addr_l      (l_addr),
        .addr_r      (r_addr),
        .busy_in_l_n (l_busy_in_n),
        .busy_in_r_n (r_busy_in_n),
        .wen_l       (wen_l),
        .wen_r       (wen_r),
        .busy_l_n    (l_busy_n),
        .busy_r_n    (r_busy_n)
    );

    dpr_mem_core #(.AW(AW), .DW(DW)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_l  (l_addr),
        .addr_r  (r_addr),
        .wdata_l (l_wdata),
        .wdata_r (r_wdata),
        .wen_l   (wen_l),
        .wen_r   (wen_r),
        .ren_l   (req_l.rd),
        .ren_r   (req_r.rd),
        .rdata_l (l_rdata),
        .rdata_r (r_rdata),
        .doe_l   (l_doe),
        .doe_r   (r_doe)
    );

endmodule

// File: rtl/dpr_checker.sv
// Port-level temporal checks for dpram_port_ctrl, attached with bind.
// Assumes: port names match the top module so implicit connection works.
module dpr_checker #(
    parameter int AW = 8,
    parameter int DW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ms_i,
    input logic          l_ce0_n,
    input logic          l_ce1,
    input logic          l_rw,
    input logic          l_oe_n,
    input logic          l_sem_n,
    input logic [AW-1:0] l_addr,
    input logic [DW-1:0] l_wdata,
    input logic          l_busy_in_n,
    input logic [DW-1:0] l_rdata,
    input logic          l_doe,
    input logic          l_busy_n,
    input logic          r_ce0_n,
    input logic          r_ce1,
    input logic          r_rw,
    input logic          r_oe_n,
    input logic          r_sem_n,
    input logic [AW-1:0] r_addr,
    input logic [DW-1:0] r_wdata,
    input logic          r_busy_in_n,
    input logic [DW-1:0] r_rdata,
    input logic          r_doe,
    input logic          r_busy_n
);

    logic l_rd_req, r_rd_req, both_on;

    // Port-level read request and same-word presence, from raw pins
    always_comb begin
        l_rd_req = !l_ce0_n && l_ce1 && l_rw && !l_oe_n && l_sem_n;
        r_rd_req = !r_ce0_n && r_ce1 && r_rw && !r_oe_n && r_sem_n;
        both_on  = !l_ce0_n && l_ce1 && l_sem_n && !r_ce0_n && r_ce1 && r_sem_n
                   && (l_addr == r_addr);
    end

    AST_L_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        l_rd_req |=> l_doe); // R3
    AST_R_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        r_rd_req |=> r_doe); // R3
    AST_L_NO_READ_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        !l_rd_req |=> !l_doe); // R4
    AST_R_NO_READ_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        !r_rd_req |=> !r_doe); // R4
    AST_HIZ_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_doe |-> l_rdata == '0) and (!r_doe |-> r_rdata == '0)); // R4
    AST_ONE_LOSER: assert property (@(posedge clk) disable iff (!rst_n)
        !(!l_busy_n && !r_busy_n)); // R6
    AST_SLAVE_BUSY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ms_i |=> (l_busy_n && r_busy_n)); // R9
    AST_BUSY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !both_on |=> (l_busy_n && r_busy_n)); // R8
    AST_READS_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (l_rw && r_rw) |=> (l_busy_n && r_busy_n)); // R5

endmodule

bind dpram_port_ctrl dpr_checker #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/dpram_port_ctrl_tb.sv
// Self-checking bench: directed corner cases plus seeded random traffic,
// compared every cycle with a behavioural model built from the requirements.
module dpram_port_ctrl_tb_top;

    localparam int  AW       = 8;
    localparam int  DW       = 9;
    localparam int  DEPTH    = 1 << AW;
    localparam time CLK_PER  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_i = 1'b1;
    logic l_ce0_n = 1'b1, l_ce1 = 1'b0, l_rw = 1'b1, l_oe_n = 1'b1, l_sem_n = 1'b1, l_busy_in_n = 1'b1;
    logic r_ce0_n = 1'b1, r_ce1 = 1'b0, r_rw = 1'b1, r_oe_n = 1'b1, r_sem_n = 1'b1, r_busy_in_n = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [DW-1:0] l_wdata = '0, r_wdata = '0;
    logic [DW-1:0] l_rdata, r_rdata;
    logic l_doe, r_doe, l_busy_n, r_busy_n;

    int checks = 0;
    int errors = 0;

    // model state
    logic [DW-1:0] m_mem [DEPTH];
    logic [DW-1:0] e_rd_l, e_rd_r;
    logic e_doe_l, e_doe_r, e_busy_l, e_busy_r;
    logic h_act_l, h_act_r, h_coll, h_loser_r;
    logic [AW-1:0] h_addr_l, h_addr_r;

    always #(CLK_PER/2) clk = ~clk;

    dpram_port_ctrl #(.AW(AW), .DW(DW)) dut_i (.*);

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic selected(input logic ce0_n, input logic ce1);
        return !ce0_n && ce1;
    endfunction

    // One clock edge of the reference behaviour
    task automatic model_edge();
        logic al, ar, wl, wr, rl, rr, coll, le, re, lose_r, wel, wer;
        al = selected(l_ce0_n, l_ce1) && l_sem_n;
        ar = selected(r_ce0_n, r_ce1) && r_sem_n;
        wl = al && !l_rw;  wr = ar && !r_rw;
        rl = al && l_rw && !l_oe_n;  rr = ar && r_rw && !r_oe_n;
        coll = al && ar && (l_addr == r_addr) && (wl || wr);
        le = h_act_l && (h_addr_l == l_addr);
        re = h_act_r && (h_addr_r == r_addr);
        if (h_coll && h_addr_l == l_addr) lose_r = h_loser_r;
        else lose_r = !(re && !le);
        if (ms_i) begin
            wel = wl && !(coll && !lose_r);
            wer = wr && !(coll && lose_r);
        end else begin
            wel = wl && l_busy_in_n;
            wer = wr && r_busy_in_n;
        end
        e_doe_l = rl;  e_doe_r = rr;
        e_rd_l = rl ? m_mem[l_addr] : '0;
        e_rd_r = rr ? m_mem[r_addr] : '0;
        if (wer) m_mem[r_addr] = r_wdata;
        if (wel) m_mem[l_addr] = l_wdata;
        e_busy_l = !(ms_i && coll && !lose_r);
        e_busy_r = !(ms_i && coll && lose_r);
        h_act_l = al;  h_act_r = ar;  h_addr_l = l_addr;  h_addr_r = r_addr;
        h_coll = coll;  h_loser_r = lose_r;
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tag, "l_doe", int'(l_doe), int'(e_doe_l));
        check(tag, "r_doe", int'(r_doe), int'(e_doe_r));
        check(tag, "l_rdata", int'(l_rdata), int'(e_rd_l));
        check(tag, "r_rdata", int'(r_rdata), int'(e_rd_r));
        check(tag, "l_busy_n", int'(l_busy_n), int'(e_busy_l));
        check(tag, "r_busy_n", int'(r_busy_n), int'(e_busy_r));
    endtask

    // op: 0 idle, 1 write, 2 read, 3 read with oe high
    task automatic drive(input bit left, input int op, input int a, input int d);
        logic c0, c1, rw, oe;
        c0 = (op == 0);  c1 = (op != 0);
        rw = (op != 1);  oe = (op == 3);
        if (left) begin
            l_ce0_n = c0; l_ce1 = c1; l_rw = rw; l_oe_n = oe; l_sem_n = 1'b1;
            l_addr = AW'(a); l_wdata = DW'(d);
        end else begin
            r_ce0_n = c0; r_ce1 = c1; r_rw = rw; r_oe_n = oe; r_sem_n = 1'b1;
            r_addr = AW'(a); r_wdata = DW'(d);
        end
    endtask

    initial begin
        #(CLK_PER * 150000);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        h_act_l = 0; h_act_r = 0; h_coll = 0; h_loser_r = 0; h_addr_l = '0; h_addr_r = '0;
        repeat (3) @(negedge clk);
        // R10: state while reset is held
        check("R10", "l_doe", int'(l_doe), 0);
        check("R10", "r_doe", int'(r_doe), 0);
        check("R10", "l_rdata", int'(l_rdata), 0);
        check("R10", "busy", int'(l_busy_n && r_busy_n), 1);
        rst_n = 1'b1;

        // R2: fill the array from the left port, with oe low during the write
        for (int a = 0; a < DEPTH; a++) begin
            drive(1, 1, a, (a * 7 + 3) & 9'h1FF);
            l_oe_n = 1'b0;
            drive(0, 0, 0, 0);
            step("R2");
        end
        // R3: plain read back
        drive(1, 2, 5, 0); step("R3");
        // R1: deselect via each chip enable, then read unchanged word
        drive(1, 1, 5, 9'h1AA); l_ce0_n = 1'b1; step("R1");
        drive(1, 1, 5, 9'h155); l_ce1 = 1'b0; step("R1");
        drive(1, 2, 5, 0); l_ce0_n = 1'b1; l_ce1 = 1'b1; step("R1");
        drive(1, 2, 5, 0); step("R1");
        // R4: oe high, semaphore select low
        drive(1, 3, 6, 0); step("R4");
        drive(1, 2, 6, 0); l_sem_n = 1'b0; step("R4");
        drive(1, 1, 6, 9'h0F0); l_sem_n = 1'b0; step("R4");
        drive(1, 2, 6, 0); step("R4");
        // R3: read-first against a same-cycle write by the other port
        drive(0, 1, 7, 9'h111); drive(1, 2, 7, 0); step("R3");
        drive(0, 0, 0, 0); step("R3");
        // R5: both read one word
        drive(1, 2, 9, 0); drive(0, 2, 9, 0); step("R5");
        step("R5");
        // R7: tie on a double write, held, then the right port leaves
        drive(1, 1, 10, 9'h0A1); drive(0, 1, 10, 9'h0B2); step("R7");
        drive(1, 1, 10, 9'h0A3); drive(0, 1, 10, 9'h0B4); step("R7");
        drive(0, 2, 11, 0); step("R8");
        drive(1, 2, 10, 0); step("R8");
        step("R7");
        // R6: right reads first, left then writes the same word and loses
        drive(1, 0, 0, 0); drive(0, 2, 12, 0); step("R6");
        drive(1, 1, 12, 9'h1EE); step("R6");
        step("R6");
        drive(1, 0, 0, 0); step("R8");
        drive(1, 2, 12, 0); drive(0, 0, 0, 0); step("R6");
        step("R6");
        // R9: slave mode, busy input blocks a write, arbiter inert
        ms_i = 1'b0; l_busy_in_n = 1'b0;
        drive(1, 1, 20, 9'h123); drive(0, 1, 20, 9'h045); step("R9");
        l_busy_in_n = 1'b1;
        drive(1, 2, 20, 0); drive(0, 0, 0, 0); step("R9");
        drive(1, 1, 21, 9'h0CC); drive(0, 1, 21, 9'h033); step("R9");
        drive(1, 2, 21, 0); drive(0, 0, 0, 0); step("R9");
        step("R9");
        ms_i = 1'b1;

        // Random traffic on a few words to provoke collisions
        void'($urandom(32'd4242));
        for (int i = 0; i < 3000; i++) begin
            drive(1, int'($urandom_range(3)), int'($urandom_range(3)), int'($urandom_range(511)));
            drive(0, int'($urandom_range(3)), int'($urandom_range(3)), int'($urandom_range(511)));
            if ($urandom_range(9) == 0) l_sem_n = 1'b0;
            if ($urandom_range(9) == 0) r_ce1 = 1'b0;
            if (i >= 2400) begin
                ms_i = 1'b0;
                l_busy_in_n = 1'($urandom_range(1));
                r_busy_in_n = 1'($urandom_range(1));
            end
            step(i < 2400 ? "R6" : "R9");
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule